// File: doc/BRIEF.md
# Dual-Issue Pipe Reservation Unit

This unit sits between a two-wide in-order decode stage and two ALU execution pipes. Each cycle it receives an older candidate in slot 0 and a younger one in slot 1. Each candidate carries a class code. The unit decides how many of the two may issue this cycle and which pipe each granted instruction uses. Some instructions break into several micro-ops, and these keep resources for one or two further cycles. The unit records those future holds in a short reservation timeline, so a later cycle of such an instruction blocks whatever would conflict with it.

There are four resources: pipe 0, pipe 1, a load/store issue port and a branch issue port. Each class needs a fixed set of these resources in its first cycle, and some classes need further sets in later cycles. Ordinary instructions may use either pipe. Multi-micro-op instructions and the single-cycle multiply use pipe 0 only. The unit takes no account of operand dependencies or predication, and it treats every instruction as unconditional.

Top module: `dual_issue_reserve`

## Requirements
- R1: An ALU (code 0) or move (code 1) instruction needs one pipe, which may be either. When both pipes are free and both slots issue, slot 0 gets pipe 0 and slot 1 gets pipe 1.
- R2: A branch (code 2) needs one pipe plus the branch port. The branch port serves at most one instruction per cycle, so a second branch-port user in the same cycle is not granted.
- R3: A single-micro-op load/store (code 4) needs one pipe plus the load/store port. The load/store port serves at most one instruction per cycle.
- R4: A single-cycle multiply (code 6) needs pipe 0 only and is never placed on pipe 1.
- R5: A two-micro-op multiply (code 7) needs both pipes in its issue cycle and pipe 0 in the next cycle.
- R6: A three-micro-op multiply (code 8) needs both pipes in its issue cycle and in the next cycle, and pipe 0 in the cycle after that.
- R7: A two-micro-op load/store (code 5) needs both pipes and the load/store port in its issue cycle, and pipe 0 plus the load/store port in the next cycle.
- R8: A call (code 3) needs only the branch port, so it can pair with an instruction that uses either pipe. The pipe index reported for a call is 0.
- R9: Slot 1 is granted only when slot 0 is granted in the same cycle, and this includes the case where slot 0 is not valid.
- R10: `busy` is high in a cycle exactly when some pipe or port is held in that cycle by an instruction that issued in an earlier cycle.
- R11: While the synchronous active-high reset is high, no grant is given, and the reset clears every pending reservation.
- R12: Class codes 9 and above are treated as ALU instructions. The pipe index output of a slot that is not granted is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s0_valid | input | 1 | Older candidate present |
| s0_cls | input | CLS_W | Older candidate class code |
| s1_valid | input | 1 | Younger candidate present |
| s1_cls | input | CLS_W | Younger candidate class code |
| s0_grant | output | 1 | Older candidate issues this cycle |
| s1_grant | output | 1 | Younger candidate issues this cycle |
| s0_pipe | output | 1 | Pipe index for the older candidate |
| s1_pipe | output | 1 | Pipe index for the younger candidate |
| busy | output | 1 | A resource is held by an earlier multi-cycle instruction |

## Verification
The bench checks the later cycles of each multi-micro-op class. A design that dropped a tail reservation would dual-issue an ALU op beside the second micro-op, or put it on pipe 0, while a pipe or the load/store port is still held. It also pairs a call with ALU, branch and three-micro-op multiply candidates. A design that charged a pipe to a call would refuse those pairings, and one that ignored the shared branch port would issue a branch alongside a call. Reset is asserted in the middle of a three-micro-op multiply, and the following cycle must show both pipes free. Codes above the defined range are also sent, to make sure they behave exactly like ALU operations.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

   // Class codes seen on the candidate inputs
   typedef enum logic [3:0] {
      CL_ALU  = 4'd0,
      CL_MOV  = 4'd1,
      CL_BR   = 4'd2,
      CL_CALL = 4'd3,
      CL_LS1  = 4'd4,
      CL_LS2  = 4'd5,
      CL_MUL1 = 4'd6,
      CL_MUL2 = 4'd7,
      CL_MUL3 = 4'd8
   } icls_e;

   // One bit per shared resource
   localparam int RES_W  = 4;
   localparam int RB_P0  = 0;
   localparam int RB_P1  = 1;
   localparam int RB_LS  = 2;
   localparam int RB_BR  = 3;

   typedef logic [RES_W-1:0] res_t;

endpackage

// File: rtl/issue_cls_decode.sv
module issue_cls_decode
   import dual_issue_pkg::*;
#(
   parameter int CLS_W = 4,
   parameter int TAIL  = 2
) (
   input  logic [CLS_W-1:0] cls,
   output res_t [TAIL:0]    need,
   output logic             flex
);

   logic code_ok;

   generate
      if (CLS_W > 4) begin : g_wide
         assign code_ok = (cls[CLS_W-1:4] == '0);
      end else begin : g_exact
         assign code_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      need = '0;
      flex = 1'b0;
      if (!code_ok) begin
         flex = 1'b1;
      end else begin
         case (icls_e'(cls[3:0]))
            CL_BR: begin
               flex = 1'b1;
               need[0][RB_BR] = 1'b1;
            end
            CL_CALL: begin
               need[0][RB_BR] = 1'b1;
            end
            CL_LS1: begin
               flex = 1'b1;
               need[0][RB_LS] = 1'b1;
            end
            CL_LS2: begin
               need[0][RB_P0] = 1'b1;
               need[0][RB_P1] = 1'b1;
               need[0][RB_LS] = 1'b1;
               need[1][RB_P0] = 1'b1;
               need[1][RB_LS] = 1'b1;
            end
            CL_MUL1: begin
               need[0][RB_P0] = 1'b1;
            end
            CL_MUL2: begin
               need[0][RB_P0] = 1'b1;
               need[0][RB_P1] = 1'b1;
               need[1][RB_P0] = 1'b1;
            end
            CL_MUL3: begin
               need[0][RB_P0] = 1'b1;
               need[0][RB_P1] = 1'b1;
               need[1][RB_P0] = 1'b1;
               need[1][RB_P1] = 1'b1;
               need[2][RB_P0] = 1'b1;
            end
            default: begin
               flex = 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/slot_fit.sv
module slot_fit
   import dual_issue_pkg::*;
#(
   parameter int TAIL = 2
) (
   input  logic          valid,
   input  logic          allow,
   input  res_t          avail,
   input  res_t [TAIL:1] held_fut,
   input  res_t [TAIL:0] need,
   input  logic          flex,
   output logic          grant,
   output logic          pipe,
   output res_t [TAIL:0] used
);

   res_t cur;
   logic pick_p1;
   logic ok;

   always_comb begin
      pick_p1 = flex && !avail[RB_P0];
      cur     = need[0];
      if (flex) begin
         if (pick_p1) cur[RB_P1] = 1'b1;
         else         cur[RB_P0] = 1'b1;
      end
      ok = ((cur & ~avail) == '0);
      for (int k = 1; k <= TAIL; k++) begin
         if ((need[k] & held_fut[k]) != '0) ok = 1'b0;
      end
      grant = valid && allow && ok;
      pipe  = grant && pick_p1;
      used  = '0;
      if (grant) begin
         used    = need;
         used[0] = cur;
      end
   end

endmodule

// File: rtl/rsv_timeline.sv
module rsv_timeline
   import dual_issue_pkg::*;
#(
   parameter int TAIL = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  res_t [TAIL:0] add_a,
   input  res_t [TAIL:0] add_b,
   output res_t [TAIL:0] held
);

   // q[k] is what is already held k cycles from now
   res_t [TAIL-1:0] q;

   generate
      for (genvar k = 0; k < TAIL; k++) begin : g_stage
         res_t nxt;
         if (k == TAIL - 1) begin : g_last
            assign nxt = add_a[k+1] | add_b[k+1];
         end else begin : g_mid
            assign nxt = q[k+1] | add_a[k+1] | add_b[k+1];
         end
         always_ff @(posedge clk) begin
            if (rst) q[k] <= '0;
            else     q[k] <= nxt;
         end
         assign held[k] = q[k];
      end
   endgenerate

   assign held[TAIL] = '0;

   // add_a[0] / add_b[0] are consumed in the current cycle only
   logic unused_now;
   assign unused_now = ^{add_a[0], add_b[0]};

endmodule

// File: rtl/dual_issue_reserve.sv
module dual_issue_reserve
   import dual_issue_pkg::*;
#(
   parameter int CLS_W = 4,
   parameter int TAIL  = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             s0_valid,
   input  logic [CLS_W-1:0] s0_cls,
   input  logic             s1_valid,
   input  logic [CLS_W-1:0] s1_cls,
   output logic             s0_grant,
   output logic             s1_grant,
   output logic             s0_pipe,
   output logic             s1_pipe,
   output logic             busy
);

   generate
      if (CLS_W < 4) begin : g_bad_cls
         $error("CLS_W must hold the 4-bit class codes");
      end
      if (TAIL < 2) begin : g_bad_tail
         $error("TAIL must cover a three micro-op instruction");
      end
   endgenerate

   res_t [TAIL:0] held;
   res_t [TAIL:0] need0, need1, used0, used1;
   res_t [TAIL:1] fut0, fut1;
   logic          flex0, flex1;
   res_t          avail0, avail1;

   issue_cls_decode #(.CLS_W(CLS_W), .TAIL(TAIL)) dec0_i (
      .cls(s0_cls), .need(need0), .flex(flex0));
   issue_cls_decode #(.CLS_W(CLS_W), .TAIL(TAIL)) dec1_i (
      .cls(s1_cls), .need(need1), .flex(flex1));

   always_comb begin
      avail0 = ~held[0];
      avail1 = avail0 & ~used0[0];
      for (int k = 1; k <= TAIL; k++) begin
         fut0[k] = held[k];
         fut1[k] = held[k] | used0[k];
      end
   end

   slot_fit #(.TAIL(TAIL)) fit0_i (
      .valid(s0_valid && !rst), .allow(1'b1), .avail(avail0),
      .held_fut(fut0), .need(need0), .flex(flex0),
      .grant(s0_grant), .pipe(s0_pipe), .used(used0));

   slot_fit #(.TAIL(TAIL)) fit1_i (
      .valid(s1_valid && !rst), .allow(s0_grant), .avail(avail1),
      .held_fut(fut1), .need(need1), .flex(flex1),
      .grant(s1_grant), .pipe(s1_pipe), .used(used1));

   rsv_timeline #(.TAIL(TAIL)) line_i (
      .clk(clk), .rst(rst), .add_a(used0), .add_b(used1), .held(held));

   assign busy = (held[0] != '0);

endmodule

// File: rtl/dual_issue_reserve_chk.sv
module dual_issue_reserve_chk
   import dual_issue_pkg::*;
#(
   parameter int CLS_W = 4
) (
   input logic             clk,
   input logic             rst,
   input logic [CLS_W-1:0] s0_cls,
   input logic [CLS_W-1:0] s1_cls,
   input logic             s0_grant,
   input logic             s1_grant,
   input logic             s0_pipe,
   input logic             s1_pipe,
   input logic             busy
);

   function automatic logic is_code(input logic [CLS_W-1:0] c, input icls_e e);
      return c == CLS_W'(e);
   endfunction

   logic br0, br1, ls0, ls1, pin0, call0, call1;
   assign br0   = is_code(s0_cls, CL_BR) || is_code(s0_cls, CL_CALL);
   assign br1   = is_code(s1_cls, CL_BR) || is_code(s1_cls, CL_CALL);
   assign ls0   = is_code(s0_cls, CL_LS1) || is_code(s0_cls, CL_LS2);
   assign ls1   = is_code(s1_cls, CL_LS1) || is_code(s1_cls, CL_LS2);
   assign call0 = is_code(s0_cls, CL_CALL);
   assign call1 = is_code(s1_cls, CL_CALL);
   assign pin0  = is_code(s0_cls, CL_MUL1) || is_code(s0_cls, CL_MUL2) ||
                  is_code(s0_cls, CL_MUL3) || is_code(s0_cls, CL_LS2);

   assert_inorder_R9: assert property (@(posedge clk) disable iff (rst)
      s1_grant |-> s0_grant);

   assert_one_branch_R2: assert property (@(posedge clk) disable iff (rst)
      (s0_grant && s1_grant) |-> !(br0 && br1));

   assert_one_ls_R3: assert property (@(posedge clk) disable iff (rst)
      (s0_grant && s1_grant) |-> !(ls0 && ls1));

   assert_pinned_R4: assert property (@(posedge clk) disable iff (rst)
      (s0_grant && pin0) |-> !s0_pipe);

   assert_distinct_pipes_R1: assert property (@(posedge clk) disable iff (rst)
      (s0_grant && s1_grant && !call0 && !call1) |-> (s0_pipe != s1_pipe));

   assert_mul2_tail_R5: assert property (@(posedge clk) disable iff (rst)
      (s0_grant && is_code(s0_cls, CL_MUL2)) |=> busy);

   assert_mul3_tail_R6: assert property (@(posedge clk) disable iff (rst)
      (s0_grant && is_code(s0_cls, CL_MUL3)) |=> busy);

   assert_reset_clears_R11: assert property (@(posedge clk)
      rst |=> !busy);

   assert_no_grant_in_reset_R11: assert property (@(posedge clk)
      rst |-> (!s0_grant && !s1_grant));

endmodule

bind dual_issue_reserve dual_issue_reserve_chk #(.CLS_W(CLS_W)) chk_i (
   .clk(clk), .rst(rst), .s0_cls(s0_cls), .s1_cls(s1_cls),
   .s0_grant(s0_grant), .s1_grant(s1_grant),
   .s0_pipe(s0_pipe), .s1_pipe(s1_pipe), .busy(busy));

// File: tb/dual_issue_reserve_tb_top.sv
module dual_issue_reserve_tb_top;
   import dual_issue_pkg::*;

   localparam int PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       s0_valid = 1'b0, s1_valid = 1'b0;
   logic [3:0] s0_cls = '0, s1_cls = '0;
   logic       s0_grant, s1_grant, s0_pipe, s1_pipe, busy;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   typedef struct {
      logic  g0, g1, p0, p1, b;
      string tag;
   } exp_t;

   exp_t sb[$];
   event smp;

   always #(PERIOD/2) clk = ~clk;

   dual_issue_reserve dut_i (
      .clk(clk), .rst(rst),
      .s0_valid(s0_valid), .s0_cls(s0_cls),
      .s1_valid(s1_valid), .s1_cls(s1_cls),
      .s0_grant(s0_grant), .s1_grant(s1_grant),
      .s0_pipe(s0_pipe), .s1_pipe(s1_pipe), .busy(busy));

   task automatic step(input logic r, input logic v0, input logic [3:0] c0,
                       input logic v1, input logic [3:0] c1,
                       input logic eg0, input logic eg1, input logic ep0,
                       input logic ep1, input logic eb, input string tag);
      exp_t e;
      @(negedge clk);
      rst = r; s0_valid = v0; s0_cls = c0; s1_valid = v1; s1_cls = c1;
      e.g0 = eg0; e.g1 = eg1; e.p0 = ep0; e.p1 = ep1; e.b = eb; e.tag = tag;
      sb.push_back(e);
      #(PERIOD/4);
      ->smp;
   endtask

   // Monitor: pops the expected item for each sampled cycle
   initial begin
      forever begin
         exp_t e;
         @(smp);
         e = sb.pop_front();
         checks++;
         if ({s0_grant, s1_grant, s0_pipe, s1_pipe, busy} !==
             {e.g0, e.g1, e.p0, e.p1, e.b}) begin
            failures++;
            $display("FAIL %s: g0 g1 p0 p1 busy actual=%b%b%b%b%b expected=%b%b%b%b%b",
                     e.tag, s0_grant, s1_grant, s0_pipe, s1_pipe, busy,
                     e.g0, e.g1, e.p0, e.p1, e.b);
         end
      end
   end

   initial begin
      #(PERIOD*5000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      // reset state, idle inputs (R11)
      step(0, 0, CL_ALU, 0, CL_ALU,   0,0,0,0,0, "R11");
      step(0, 1, CL_ALU, 1, CL_ALU,   1,1,0,1,0, "R1");
      step(0, 1, CL_MOV, 1, CL_ALU,   1,1,0,1,0, "R1");
      step(0, 1, CL_ALU, 1, CL_BR,    1,1,0,1,0, "R2");
      step(0, 1, CL_BR,  1, CL_BR,    1,0,0,0,0, "R2");
      step(0, 1, CL_LS1, 1, CL_LS1,   1,0,0,0,0, "R3");
      step(0, 1, CL_BR,  1, CL_LS1,   1,1,0,1,0, "R3");
      step(0, 1, CL_MUL1,1, CL_ALU,   1,1,0,1,0, "R4");
      step(0, 1, CL_ALU, 1, CL_MUL1,  1,0,0,0,0, "R4");
      step(0, 1, CL_MUL2,1, CL_ALU,   1,0,0,0,0, "R5");
      step(0, 1, CL_ALU, 1, CL_ALU,   1,0,1,0,1, "R5");
      step(0, 1, CL_MUL3,1, CL_ALU,   1,0,0,0,0, "R6");
      step(0, 1, CL_ALU, 1, CL_ALU,   0,0,0,0,1, "R10");
      step(0, 1, CL_ALU, 1, CL_ALU,   1,0,1,0,1, "R6");
      step(0, 1, CL_ALU, 1, CL_ALU,   1,1,0,1,0, "R6");
      step(0, 1, CL_LS2, 1, CL_LS1,   1,0,0,0,0, "R7");
      step(0, 1, CL_LS1, 1, CL_ALU,   0,0,0,0,1, "R7");
      step(0, 1, CL_LS2, 0, CL_ALU,   1,0,0,0,0, "R7");
      step(0, 1, CL_ALU, 1, CL_LS1,   1,0,1,0,1, "R7");
      step(0, 0, CL_ALU, 1, CL_ALU,   0,0,0,0,0, "R9");
      step(0, 1, CL_CALL,1, CL_ALU,   1,1,0,0,0, "R8");
      step(0, 1, CL_MUL3,1, CL_CALL,  1,1,0,0,0, "R8");
      step(0, 1, CL_CALL,1, CL_BR,    1,0,0,0,1, "R2");
      step(0, 1, CL_ALU, 1, CL_MUL1,  1,0,1,0,1, "R6");
      step(0, 1, CL_MUL3,0, CL_ALU,   1,0,0,0,0, "R6");
      step(1, 1, CL_ALU, 1, CL_ALU,   0,0,0,0,1, "R11");
      step(0, 1, CL_ALU, 1, CL_ALU,   1,1,0,1,0, "R11");
      step(0, 1, 4'd9,   1, 4'd15,    1,1,0,1,0, "R12");
      step(0, 1, CL_MOV, 1, CL_MUL2,  1,0,0,0,0, "R5");
      step(0, 1, CL_MUL2,1, CL_CALL,  1,1,0,0,0, "R8");
      step(0, 1, CL_ALU, 1, CL_ALU,   1,0,1,0,1, "R5");
      @(negedge clk);
      s0_valid = 0; s1_valid = 0;
      #1;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule